// File: doc/BRIEF.md
# Write-Through Two-State Snooping Coherence Controller

This block sits beside one write-through cache that does not allocate on writes, and keeps that cache coherent with the other agents on a shared bus. The bus carries one transaction at a time, in a single total order. The controller holds a small direct-mapped array that records a tag and a state for each line. A line is either Valid or Invalid. The data array and the memory controller are not part of the block. From the memory side, the block sees only a single response-valid strobe.

The processor side presents one load or store at a time, and `cpuReady` stalls it while a request is in flight. A load that hits completes with no bus traffic. A load that misses issues a shared read and fills the line. Every store issues an exclusive read on the bus and never allocates a line. On the snoop side, the block watches the commands of the other agents. An exclusive read from another agent that matches a stored Valid tag invalidates that line. A shared read from another agent changes nothing.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpuReady` is 1, `busReqValid` is 0 and `cpuDone` is 0.
- R2: A load whose line is Valid with a matching tag raises no bus request, and `cpuDone` pulses in the cycle after the request is accepted.
- R3: A load that misses requests a shared read (`busReqCmd` = 0) at the block-aligned address. The address splits into offset bits [log2(BLOCK_BYTES)-1:0], then index bits above them, then the tag. The line becomes Valid with that tag when the memory response arrives.
- R4: Every store requests an exclusive read (`busReqCmd` = 1), whatever the line's state. A store leaves an Invalid line Invalid and a Valid line Valid.
- R5: A snooped exclusive read (`snoopCmd` = 1) from another agent whose index and tag match a Valid line makes that line Invalid.
- R6: A snooped shared read (`snoopCmd` = 0) leaves every line unchanged.
- R7: A snooped transaction whose tag differs from the stored tag at its index leaves that line unchanged.
- R8: A snooped exclusive read to the pending load's block, seen after the grant and before the memory response, lets the load complete but blocks the fill, so the line stays Invalid.
- R9: One request is outstanding at a time. `cpuReady` is low from acceptance until `cpuDone`. A miss or a store raises `cpuDone` only after both the grant and the memory response.
- R10: Once raised, `busReqValid` stays high, with a stable command and address, until `busGrant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqStore | input | 1 | 1 = store, 0 = load |
| cpuReqAddr | input | ADDR_W | Processor byte address |
| cpuReady | output | 1 | Controller idle and able to accept a request |
| cpuDone | output | 1 | One-cycle completion pulse |
| busReqValid | output | 1 | Own bus transaction requested |
| busReqCmd | output | 1 | 0 = shared read, 1 = exclusive read |
| busReqAddr | output | ADDR_W | Block-aligned address of the own transaction |
| busGrant | input | 1 | Bus arbiter grants the own transaction |
| memRespValid | input | 1 | Memory response for the own transaction |
| snoopValid | input | 1 | Another agent's transaction is on the bus |
| snoopCmd | input | 1 | Snooped command: 0 = shared read, 1 = exclusive read |
| snoopAddr | input | ADDR_W | Snooped address |

## Verification
The hardest case to reach is a race. Another agent's exclusive read to the same block has to land in the narrow window between the block's own grant and its memory response. The bench holds back the memory response for one cycle after granting a load miss, and drives a matching snoop in that cycle. A second load to the same block then shows, through whether a bus request appears, that the fill was blocked. A delayed grant is used the same way, to show that completion waits for both the grant and the response.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } ctrlState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic latchReq;   // capture the processor request
    logic waitPhase;  // own transaction granted, response pending
    logic fillReq;    // memory response for the pending request
  } dpStrobe_t;

  localparam logic CMD_GETS = 1'b0;
  localparam logic CMD_GETX = 1'b1;

endpackage

// File: rtl/wt_snoop_dp.sv
module wt_snoop_dp
  import wt_snoop_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic              cpuReqStore,
  input  logic              snoopValid,
  input  logic              snoopCmd,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              reqHit,
  output logic              pendStore,
  output logic [ADDR_W-1:0] pendBlockAddr
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic              validQ [ENTRIES];
  logic [TAG_W-1:0]  tagQ   [ENTRIES];

  logic [ADDR_W-1:0] pendAddrQ;
  logic              pendStoreQ;
  logic              killQ;

  logic [IDX_W-1:0]  reqIdx, snIdx, pendIdx;
  logic [TAG_W-1:0]  reqTag, snTag, pendTag;
  logic              snoopHit, killNow, killHit, fillWe;

  assign reqIdx  = cpuReqAddr[OFF_W +: IDX_W];
  assign reqTag  = cpuReqAddr[ADDR_W-1 -: TAG_W];
  assign snIdx   = snoopAddr[OFF_W +: IDX_W];
  assign snTag   = snoopAddr[ADDR_W-1 -: TAG_W];
  assign pendIdx = pendAddrQ[OFF_W +: IDX_W];
  assign pendTag = pendAddrQ[ADDR_W-1 -: TAG_W];

  assign reqHit   = validQ[reqIdx] && (tagQ[reqIdx] == reqTag);
  assign snoopHit = snoopValid && (snoopCmd == CMD_GETX)
                    && validQ[snIdx] && (tagQ[snIdx] == snTag);

  // Another agent's exclusive read to the pending block after our grant
  assign killHit = strobe.waitPhase && snoopValid && (snoopCmd == CMD_GETX)
                   && (snoopAddr[ADDR_W-1:OFF_W] == pendAddrQ[ADDR_W-1:OFF_W]);
  assign killNow = killQ || killHit;
  assign fillWe  = strobe.fillReq && !pendStoreQ && !killNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddrQ  <= '0;
      pendStoreQ <= 1'b0;
    end else if (strobe.latchReq) begin
      pendAddrQ  <= {cpuReqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      pendStoreQ <= cpuReqStore;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                killQ <= 1'b0;
    else if (strobe.latchReq) killQ <= 1'b0;
    else if (killHit)         killQ <= 1'b1;
  end

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_line
      logic fillHere, invHere;
      assign fillHere = fillWe && (pendIdx == IDX_W'(i));
      assign invHere  = snoopHit && (snIdx == IDX_W'(i));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ[i] <= 1'b0;
          tagQ[i]   <= '0;
        end else if (fillHere) begin
          validQ[i] <= 1'b1;
          tagQ[i]   <= pendTag;
        end else if (invHere) begin
          validQ[i] <= 1'b0;
        end
      end
    end
  endgenerate

  assign pendStore     = pendStoreQ;
  assign pendBlockAddr = pendAddrQ;

  // R5
  snoop_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snoopHit && !(fillWe && pendIdx == snIdx)) |=> !validQ[$past(snIdx)]);

  // R8
  kill_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillReq && !pendStoreQ && killQ)
      |=> !(validQ[$past(pendIdx)] && tagQ[$past(pendIdx)] == $past(pendTag)));

endmodule

// File: rtl/wt_snoop_fsm.sv
module wt_snoop_fsm
  import wt_snoop_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReqValid,
  input  logic      cpuReqStore,
  input  logic      reqHit,
  input  logic      busGrant,
  input  logic      memRespValid,
  output dpStrobe_t strobe,
  output logic      cpuReady,
  output logic      cpuDone,
  output logic      busReqValid
);

  ctrlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReqValid) begin
          strobe.latchReq = 1'b1;
          stateD = (!cpuReqStore && reqHit) ? ST_DONE : ST_REQ;
        end
      end
      ST_REQ: begin
        if (busGrant) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        strobe.waitPhase = 1'b1;
        if (memRespValid) begin
          strobe.fillReq = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign cpuReady    = (stateQ == ST_IDLE);
  assign cpuDone     = (stateQ == ST_DONE);
  assign busReqValid = (stateQ == ST_REQ);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busGrant) |=> busReqValid);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && cpuReqValid) |=> !cpuReady);

  // R9
  done_needs_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && !memRespValid) |=> !cpuDone);

endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
  import wt_snoop_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  input  logic              cpuReqStore,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  output logic              cpuReady,
  output logic              cpuDone,
  output logic              busReqValid,
  output logic              busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  input  logic              busGrant,
  input  logic              memRespValid,
  input  logic              snoopValid,
  input  logic              snoopCmd,
  input  logic [ADDR_W-1:0] snoopAddr
);

  dpStrobe_t strobe;
  logic      reqHit, pendStore;

  wt_snoop_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReqValid  (cpuReqValid),
    .cpuReqStore  (cpuReqStore),
    .reqHit       (reqHit),
    .busGrant     (busGrant),
    .memRespValid (memRespValid),
    .strobe       (strobe),
    .cpuReady     (cpuReady),
    .cpuDone      (cpuDone),
    .busReqValid  (busReqValid)
  );

  wt_snoop_dp #(
    .ENTRIES     (ENTRIES),
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cpuReqAddr    (cpuReqAddr),
    .cpuReqStore   (cpuReqStore),
    .snoopValid    (snoopValid),
    .snoopCmd      (snoopCmd),
    .snoopAddr     (snoopAddr),
    .reqHit        (reqHit),
    .pendStore     (pendStore),
    .pendBlockAddr (busReqAddr)
  );

  assign busReqCmd = pendStore ? CMD_GETX : CMD_GETS;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (cpuReady && !busReqValid && !cpuDone));

  // R10
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busGrant) |=> ($stable(busReqCmd) && $stable(busReqAddr)));

endmodule

// File: tb/wt_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module wt_snoop_ctrl_tb_top;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReqValid = 1'b0;
  logic              cpuReqStore = 1'b0;
  logic [ADDR_W-1:0] cpuReqAddr = '0;
  logic              cpuReady, cpuDone, busReqValid, busReqCmd;
  logic [ADDR_W-1:0] busReqAddr;
  logic              busGrant = 1'b0;
  logic              memRespValid = 1'b0;
  logic              snoopValid = 1'b0;
  logic              snoopCmd = 1'b0;
  logic [ADDR_W-1:0] snoopAddr = '0;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  wt_snoop_ctrl dut_i (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqStore(cpuReqStore), .cpuReqAddr(cpuReqAddr),
    .cpuReady(cpuReady), .cpuDone(cpuDone),
    .busReqValid(busReqValid), .busReqCmd(busReqCmd), .busReqAddr(busReqAddr),
    .busGrant(busGrant), .memRespValid(memRespValid),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd), .snoopAddr(snoopAddr)
  );

  // kind: 0 load, 1 store, 2 snooped shared read, 3 snooped exclusive read
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic        expBus;
    logic        expCmd;
  } vec_t;

  localparam logic [31:0] A = 32'h0000_1040;  // index 2
  localparam logic [31:0] B = 32'h0000_3040;  // index 2, other tag
  localparam logic [31:0] C = 32'h0000_1060;  // index 3
  localparam logic [31:0] D = 32'h0000_50A0;  // index 5
  localparam logic [31:0] E = 32'h0000_70C4;  // index 6

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, A,        1'b1, 1'b0},
    '{2'd0, A + 4,    1'b0, 1'b0},
    '{2'd1, A,        1'b1, 1'b1},
    '{2'd0, A,        1'b0, 1'b0},
    '{2'd1, C,        1'b1, 1'b1},
    '{2'd0, C,        1'b1, 1'b0},
    '{2'd2, A,        1'b0, 1'b0},
    '{2'd0, A,        1'b0, 1'b0},
    '{2'd3, B,        1'b0, 1'b0},
    '{2'd0, A,        1'b0, 1'b0},
    '{2'd3, A + 8,    1'b0, 1'b0},
    '{2'd0, A,        1'b1, 1'b0},
    '{2'd0, B,        1'b1, 1'b0},
    '{2'd0, A,        1'b1, 1'b0}
  };

  function automatic string rowTag(input int r);
    case (r)
      0:  return "R3 load miss";
      1:  return "R2 load hit";
      2:  return "R4 store to valid";
      3:  return "R4 line stays valid";
      4:  return "R4 store to invalid";
      5:  return "R4 no allocate";
      7:  return "R6 shared snoop ignored";
      9:  return "R7 tag mismatch ignored";
      11: return "R5 exclusive snoop invalidates";
      12: return "R3 conflict fill";
      13: return "R3 evicted line misses";
      default: return "R3 misc";
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic snoop(input logic cmd, input logic [31:0] a);
    @(negedge clk);
    snoopValid = 1'b1; snoopCmd = cmd; snoopAddr = a;
    @(negedge clk);
    snoopValid = 1'b0;
  endtask

  task automatic runOp(input logic st, input logic [31:0] a, input int grantDelay,
                       input bit killInWait, output logic sawBus,
                       output logic sawCmd, output logic [31:0] sawAddr);
    sawBus = 1'b0; sawCmd = 1'b0; sawAddr = '0;
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqStore = st; cpuReqAddr = a;
    @(negedge clk);
    cpuReqValid = 1'b0;
    if (cpuDone) begin
      check(busReqValid == 1'b0, "R2 no bus on hit", 32'(busReqValid), 32'd0);
      return;
    end
    sawBus = busReqValid; sawCmd = busReqCmd; sawAddr = busReqAddr;
    check(cpuReady == 1'b0, "R9 busy after accept", 32'(cpuReady), 32'd0);
    for (int k = 0; k < grantDelay; k++) begin
      @(negedge clk);
      check(busReqValid == 1'b1 && busReqAddr == sawAddr && busReqCmd == sawCmd,
            "R10 request held", 32'(busReqValid), 32'd1);
      check(cpuDone == 1'b0, "R9 no done before grant", 32'(cpuDone), 32'd0);
    end
    busGrant = 1'b1;
    @(negedge clk);
    busGrant = 1'b0;
    if (killInWait) begin
      snoopValid = 1'b1; snoopCmd = 1'b1; snoopAddr = a;
      @(negedge clk);
      snoopValid = 1'b0;
    end
    check(cpuDone == 1'b0, "R9 no done before response", 32'(cpuDone), 32'd0);
    memRespValid = 1'b1;
    @(negedge clk);
    memRespValid = 1'b0;
    check(cpuDone == 1'b1, "R9 done after response", 32'(cpuDone), 32'd1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic        b, c;
    logic [31:0] ad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cpuReady == 1'b1 && busReqValid == 1'b0 && cpuDone == 1'b0,
          "R1 reset outputs", {cpuReady, busReqValid, cpuDone}, 32'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuReady == 1'b1, "R1 idle after reset", 32'(cpuReady), 32'd1);
    // R1 all lines Invalid: a load to E misses
    runOp(1'b0, E, 0, 1'b0, b, c, ad);
    check(b == 1'b1, "R1 line invalid after reset", 32'(b), 32'd1);

    for (int r = 0; r < NVEC; r++) begin
      if (VECS[r].kind >= 2'd2) begin
        snoop(VECS[r].kind[0], VECS[r].addr);
      end else begin
        runOp(VECS[r].kind[0], VECS[r].addr, 0, 1'b0, b, c, ad);
        check(b == VECS[r].expBus, rowTag(r), 32'(b), 32'(VECS[r].expBus));
        if (VECS[r].expBus) begin
          check(c == VECS[r].expCmd, "R3 R4 command", 32'(c), 32'(VECS[r].expCmd));
          check(ad == {VECS[r].addr[31:5], 5'b0}, "R3 aligned address",
                ad, {VECS[r].addr[31:5], 5'b0});
        end
      end
    end

    // R8 exclusive snoop between grant and response blocks the fill
    runOp(1'b0, D, 0, 1'b1, b, c, ad);
    check(b == 1'b1, "R8 first load misses", 32'(b), 32'd1);
    runOp(1'b0, D, 0, 1'b0, b, c, ad);
    check(b == 1'b1, "R8 fill blocked so load misses again", 32'(b), 32'd1);
    runOp(1'b0, D, 0, 1'b0, b, c, ad);
    check(b == 1'b0, "R8 later fill succeeds", 32'(b), 32'd0);

    // R9 R10 delayed grant on a store
    runOp(1'b1, D + 4, 3, 1'b0, b, c, ad);
    check(b == 1'b1 && c == 1'b1, "R4 store with delayed grant", {b, c}, 32'b11);
    runOp(1'b0, D, 0, 1'b0, b, c, ad);
    check(b == 1'b0, "R4 store keeps line valid", 32'(b), 32'd0);

    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule